// File: doc/BRIEF.md
# MMU Fault Cause Encoder

This block sits beside the address-translation lookup of a processor core. When the lookup reports a failed access, the core presents a 3-bit result code, the kind of access (load, store or instruction fetch) and the virtual address that faulted. The block picks the exception code for the fault and updates the registers that fault handlers later read. It then raises a one-cycle exception strobe that carries the selected code.

Faults that found no translation entry at all go to a separate refill register set. That set holds the full faulting address and the page-pair number, and a refill-active flag stays set until the handler signals its return. Every other fault goes to the ordinary register set. That set holds an entry-high value aligned to a double page, plus a bad-address register. The bad-address register is frozen while a debug hold input is high. The page-pair number is taken from the 64-bit or the 32-bit address layout, chosen per access.

Top module: `xlat_fault_unit`

## Requirements
- R1: After reset, exc_strobe, exc_code, refill_badaddr, refill_vpn, badaddr, entry_hi and refill_active are all zero.
- R2: Each cycle in which fault_valid is high at a rising edge produces exc_strobe high for exactly the following cycle, with exc_code valid at that time. A cycle without fault_valid produces exc_strobe low in the following cycle.
- R3: Result code 0 (bad address) and the reserved code 7 both select exc_code 0x08 for a fetch (acc_type 2) and 0x09 for a load (acc_type 0), a store (acc_type 1) or acc_type 3.
- R4: Result codes 1 (no entry) and 2 (entry not valid) select a page-invalid code by access type: 0x01 for a load, 0x02 for a store, 0x03 for a fetch. acc_type 3 is treated as a load.
- R5: Result code 3 (store to a clean page) selects 0x04. Code 5 (read inhibited) selects 0x05, code 4 (execute inhibited) selects 0x06 and code 6 (privilege violation) selects 0x07.
- R6: On result code 1, refill_badaddr takes the whole vaddr. refill_vpn takes vaddr[47:13] when mode64 is 1, and {16'b0, vaddr[31:13]} when mode64 is 0. badaddr and entry_hi keep their values.
- R7: On any result code other than 1, entry_hi takes vaddr with bits [12:0] cleared, and refill_badaddr and refill_vpn keep their values.
- R8: On a result code other than 1, badaddr takes vaddr only when dbg_hold is 0. When dbg_hold is 1, badaddr keeps its value.
- R9: refill_active is set by a result-code-1 fault and cleared by refill_return. When both happen in the same cycle, refill_return wins and the flag ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | A fault is presented this cycle |
| res_code | input | 3 | Translation result code |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| vaddr | input | 48 | Faulting virtual address |
| mode64 | input | 1 | 1 selects the 64-bit page-pair layout |
| dbg_hold | input | 1 | Freezes badaddr while high |
| refill_return | input | 1 | Return-from-refill pulse |
| exc_strobe | output | 1 | One-cycle exception strobe |
| exc_code | output | 6 | Selected exception code |
| refill_badaddr | output | 48 | Refill bad-address register |
| refill_vpn | output | 35 | Refill page-pair number field |
| badaddr | output | 48 | Ordinary bad-address register |
| entry_hi | output | 48 | Ordinary entry-high, double-page aligned |
| refill_active | output | 1 | Refill in progress |

## Verification
The bench builds the block with its default parameters: a 48-bit address and 4 KiB pages, so the page-pair boundary falls at bit 13. With these values the whole decision space is small. The bench sweeps all eight result codes, all four access types, both address modes and both debug-hold settings, each with a different address, and checks the outcome against a register model held in the bench. It also drives the refill return pulse on its own and together with a no-entry fault, to cover the flag priority.

// File: rtl/xfe_pkg.sv
package xfe_pkg;

  typedef enum logic [2:0] {
    RES_BADADDR = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_DIRTY   = 3'd3,
    RES_XINH    = 3'd4,
    RES_RINH    = 3'd5,
    RES_PRIV    = 3'd6,
    RES_RSVD    = 3'd7
  } xlat_res_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int EXC_W = 6;
  typedef logic [EXC_W-1:0] exc_t;

  localparam exc_t EXC_PGINV_LD = 6'h01;
  localparam exc_t EXC_PGINV_ST = 6'h02;
  localparam exc_t EXC_PGINV_IF = 6'h03;
  localparam exc_t EXC_PGMOD    = 6'h04;
  localparam exc_t EXC_NOREAD   = 6'h05;
  localparam exc_t EXC_NOEXEC   = 6'h06;
  localparam exc_t EXC_PRIVPG   = 6'h07;
  localparam exc_t EXC_ADDR_IF  = 6'h08;
  localparam exc_t EXC_ADDR_MEM = 6'h09;

  typedef struct packed {
    logic refill;
    exc_t code;
  } fault_dec_t;

endpackage

// File: rtl/xfe_code_map.sv
module xfe_code_map
  import xfe_pkg::*;
(
  input  logic [2:0] res_code,
  input  logic [1:0] acc_type,
  output fault_dec_t dec
);

  exc_t pg_inv_code;
  exc_t addr_code;

  always_comb begin
    unique case (acc_e'(acc_type))
      ACC_STORE: pg_inv_code = EXC_PGINV_ST;
      ACC_FETCH: pg_inv_code = EXC_PGINV_IF;
      default:   pg_inv_code = EXC_PGINV_LD;
    endcase
    addr_code = (acc_e'(acc_type) == ACC_FETCH) ? EXC_ADDR_IF : EXC_ADDR_MEM;
  end

  always_comb begin
    dec.refill = 1'b0;
    unique case (xlat_res_e'(res_code))
      RES_NOMATCH: begin
        dec.refill = 1'b1;
        dec.code   = pg_inv_code;
      end
      RES_INVALID: dec.code = pg_inv_code;
      RES_DIRTY:   dec.code = EXC_PGMOD;
      RES_XINH:    dec.code = EXC_NOEXEC;
      RES_RINH:    dec.code = EXC_NOREAD;
      RES_PRIV:    dec.code = EXC_PRIVPG;
      default:     dec.code = addr_code;
    endcase
  end

endmodule

// File: rtl/xfe_addr_fields.sv
module xfe_addr_fields #(
  parameter int VA_W       = 48,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [VA_W-1:0]              vaddr,
  input  logic                         mode64,
  output logic [VA_W-PAGE_SHIFT-2:0]   vpn,
  output logic [VA_W-1:0]              ehi
);

  localparam int DP      = PAGE_SHIFT + 1;
  localparam int VPN_W   = VA_W - DP;
  localparam int VPN32_W = 32 - DP;
  localparam logic [VA_W-1:0] EHI_MASK = {{VPN_W{1'b1}}, {DP{1'b0}}};

  for (genvar i = 0; i < VPN_W; i++) begin : g_vpn
    if (i < VPN32_W) begin : g_both
      assign vpn[i] = vaddr[i+DP];
    end else begin : g_wide
      assign vpn[i] = vaddr[i+DP] & mode64;
    end
  end

  assign ehi = vaddr & EHI_MASK;

endmodule

// File: rtl/xfe_report_regs.sv
module xfe_report_regs
  import xfe_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int VPN_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_valid,
  input  fault_dec_t       dec,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [VPN_W-1:0] vpn,
  input  logic [VA_W-1:0]  ehi,
  input  logic             dbg_hold,
  input  logic             refill_return,
  output logic             strobe_q,
  output exc_t             code_q,
  output logic [VA_W-1:0]  rbad_q,
  output logic [VPN_W-1:0] rvpn_q,
  output logic [VA_W-1:0]  bad_q,
  output logic [VA_W-1:0]  ehi_q,
  output logic             flag_q
);

  logic strobe_d, code_en, rfl_en, bad_en, ehi_en, flag_d;

  always_comb begin
    strobe_d = fault_valid;
    code_en  = fault_valid;
    rfl_en   = fault_valid & dec.refill;
    ehi_en   = fault_valid & ~dec.refill;
    bad_en   = ehi_en & ~dbg_hold;
    if (refill_return)
      flag_d = 1'b0;
    else if (rfl_en)
      flag_d = 1'b1;
    else
      flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      code_q   <= '0;
      rbad_q   <= '0;
      rvpn_q   <= '0;
      bad_q    <= '0;
      ehi_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      flag_q   <= flag_d;
      if (code_en) code_q <= dec.code;
      if (rfl_en) begin
        rbad_q <= vaddr;
        rvpn_q <= vpn;
      end
      if (ehi_en) ehi_q <= ehi;
      if (bad_en) bad_q <= vaddr;
    end
  end

endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit #(
  parameter int VA_W       = 48,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fault_valid,
  input  logic [2:0]                 res_code,
  input  logic [1:0]                 acc_type,
  input  logic [VA_W-1:0]            vaddr,
  input  logic                       mode64,
  input  logic                       dbg_hold,
  input  logic                       refill_return,
  output logic                       exc_strobe,
  output logic [5:0]                 exc_code,
  output logic [VA_W-1:0]            refill_badaddr,
  output logic [VA_W-PAGE_SHIFT-2:0] refill_vpn,
  output logic [VA_W-1:0]            badaddr,
  output logic [VA_W-1:0]            entry_hi,
  output logic                       refill_active
);

  localparam int VPN_W = VA_W - PAGE_SHIFT - 1;

  xfe_pkg::fault_dec_t dec;
  logic [VPN_W-1:0]    vpn_c;
  logic [VA_W-1:0]     ehi_c;

  xfe_code_map u_map (
    .res_code (res_code),
    .acc_type (acc_type),
    .dec      (dec)
  );

  xfe_addr_fields #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_fields (
    .vaddr  (vaddr),
    .mode64 (mode64),
    .vpn    (vpn_c),
    .ehi    (ehi_c)
  );

  xfe_report_regs #(.VA_W(VA_W), .VPN_W(VPN_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_valid   (fault_valid),
    .dec           (dec),
    .vaddr         (vaddr),
    .vpn           (vpn_c),
    .ehi           (ehi_c),
    .dbg_hold      (dbg_hold),
    .refill_return (refill_return),
    .strobe_q      (exc_strobe),
    .code_q        (exc_code),
    .rbad_q        (refill_badaddr),
    .rvpn_q        (refill_vpn),
    .bad_q         (badaddr),
    .ehi_q         (entry_hi),
    .flag_q        (refill_active)
  );

endmodule

// File: rtl/xlat_fault_unit_chk.sv
module xlat_fault_unit_chk #(
  parameter int VA_W       = 48,
  parameter int PAGE_SHIFT = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fault_valid,
  input logic [2:0]                 res_code,
  input logic [1:0]                 acc_type,
  input logic [VA_W-1:0]            vaddr,
  input logic                       mode64,
  input logic                       dbg_hold,
  input logic                       refill_return,
  input logic                       exc_strobe,
  input logic [5:0]                 exc_code,
  input logic [VA_W-1:0]            refill_badaddr,
  input logic [VA_W-PAGE_SHIFT-2:0] refill_vpn,
  input logic [VA_W-1:0]            badaddr,
  input logic [VA_W-1:0]            entry_hi,
  input logic                       refill_active
);

  localparam int DP      = PAGE_SHIFT + 1;
  localparam int VPN_W   = VA_W - DP;
  localparam int VPN32_W = 32 - DP;

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> exc_strobe);
  assert_strobe_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> !exc_strobe);

  assert_fetch_pginv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && (res_code == 3'd1 || res_code == 3'd2) && acc_type == 2'd2)
      |=> exc_code == 6'h03);

  assert_refill_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && res_code == 3'd1) |=> refill_badaddr == $past(vaddr));
  assert_refill_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && res_code == 3'd1 && !mode64)
      |=> refill_vpn[VPN_W-1:VPN32_W] == '0);
  assert_refill_keeps_ehi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && res_code == 3'd1) |=> $stable(entry_hi) && $stable(badaddr));

  assert_ehi_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && res_code != 3'd1)
      |=> entry_hi[DP-1:0] == '0 && entry_hi[VA_W-1:DP] == $past(vaddr[VA_W-1:DP]));
  assert_refill_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && res_code != 3'd1) |=> $stable(refill_badaddr) && $stable(refill_vpn));

  assert_dbg_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && res_code != 3'd1 && dbg_hold) |=> $stable(badaddr));

  assert_return_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refill_return |=> !refill_active);
  assert_refill_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && res_code == 3'd1 && !refill_return) |=> refill_active);

endmodule

bind xlat_fault_unit xlat_fault_unit_chk #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (.*);

// File: tb/xlat_fault_unit_bench.sv
`timescale 1ns/1ps
module xlat_fault_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_valid, mode64, dbg_hold, refill_return;
  logic [2:0]  res_code;
  logic [1:0]  acc_type;
  logic [47:0] vaddr;
  logic        exc_strobe, refill_active;
  logic [5:0]  exc_code;
  logic [47:0] refill_badaddr, badaddr, entry_hi;
  logic [34:0] refill_vpn;

  int total = 0;
  int bad   = 0;

  logic [47:0] m_rbad, m_bad, m_ehi;
  logic [34:0] m_rvpn;
  logic        m_flag;

  always #4 clk = ~clk;

  xlat_fault_unit u_xlat_fault_unit (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_code(input logic [2:0] r, input logic [1:0] a);
    logic [5:0] inv;
    inv = (a == 2'd1) ? 6'h02 : (a == 2'd2) ? 6'h03 : 6'h01;
    case (r)
      3'd1, 3'd2: return inv;
      3'd3: return 6'h04;
      3'd4: return 6'h06;
      3'd5: return 6'h05;
      3'd6: return 6'h07;
      default: return (a == 2'd2) ? 6'h08 : 6'h09;
    endcase
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " R6 refill_badaddr"}, 64'(refill_badaddr), 64'(m_rbad));
    chk({tag, " R6 refill_vpn"}, 64'(refill_vpn), 64'(m_rvpn));
    chk({tag, " R8 badaddr"}, 64'(badaddr), 64'(m_bad));
    chk({tag, " R7 entry_hi"}, 64'(entry_hi), 64'(m_ehi));
    chk({tag, " R9 refill_active"}, 64'(refill_active), 64'(m_flag));
  endtask

  task automatic fault(input logic [2:0] r, input logic [1:0] a, input logic [47:0] va,
                       input logic m, input logic d, input logic ret);
    fault_valid = 1'b1; res_code = r; acc_type = a; vaddr = va;
    mode64 = m; dbg_hold = d; refill_return = ret;
    if (r == 3'd1) begin
      m_rbad = va;
      m_rvpn = m ? va[47:13] : {16'b0, va[31:13]};
      m_flag = !ret;
    end else begin
      m_ehi = {va[47:13], 13'b0};
      if (!d) m_bad = va;
      if (ret) m_flag = 1'b0;
    end
    @(negedge clk);
    fault_valid = 1'b0; refill_return = 1'b0;
    chk("R2 strobe high", 64'(exc_strobe), 64'd1);
    chk("R3 R4 R5 exc_code", 64'(exc_code), 64'(exp_code(r, a)));
    check_state("fault");
    @(negedge clk);
    chk("R2 strobe single", 64'(exc_strobe), 64'd0);
  endtask

  task automatic pulse_return();
    refill_return = 1'b1;
    m_flag = 1'b0;
    @(negedge clk);
    refill_return = 1'b0;
    check_state("return");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fault_valid = 1'b0; res_code = '0; acc_type = '0; vaddr = '0;
    mode64 = 1'b0; dbg_hold = 1'b0; refill_return = 1'b0;
    m_rbad = '0; m_bad = '0; m_ehi = '0; m_rvpn = '0; m_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobe", 64'(exc_strobe), 64'd0);
    chk("R1 code", 64'(exc_code), 64'd0);
    check_state("R1 reset");

    for (int idx = 0; idx < 128; idx++) begin
      logic [47:0] va;
      va = 48'hA5C3_1E7F_9B2D ^ (48'(idx) * 48'h0001_0203_0405) ^ {idx[6:0], 41'h1_2345_6789};
      fault(idx[6:4], idx[3:2], va, idx[1], idx[0], 1'b0);
      if (idx % 9 == 8) pulse_return();
    end

    // R9: return and no-entry fault together, return wins
    fault(3'd1, 2'd0, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1);
    chk("R9 same-cycle return wins", 64'(refill_active), 64'd0);
    fault(3'd1, 2'd1, 48'h0000_8000_2000, 1'b0, 1'b1, 1'b0);
    chk("R9 set by no-entry", 64'(refill_active), 64'd1);
    fault(3'd3, 2'd1, 48'h1234_5678_9ABC, 1'b1, 1'b1, 1'b0);
    chk("R9 other fault keeps flag", 64'(refill_active), 64'd1);
    pulse_return();
    chk("R9 cleared by return", 64'(refill_active), 64'd0);
    // R8 boundary: all ones address with hold, then released
    fault(3'd2, 2'd2, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
    fault(3'd7, 2'd3, 48'h0000_0000_1FFF, 1'b0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule